// File: doc/BRIEF.md
# Filter Output Integrator

This block keeps a running signed sum of the results produced by a digital filter. Two 16-bit signed result streams arrive at its inputs, each with a valid strobe: one taken before the decimator and one taken after it. A configuration bit picks which of the two streams feeds the sum. Each accepted sample is sign-extended and added into a wide accumulator. The sum saturates at the signed limits of that accumulator, and a sticky flag records that saturation happened.

The integrator can be started, held and cleared through writes to an 8-bit control port. It can also be driven by three external trigger lines. Each trigger line acts on its rising edge, and only when its own gate bit is set. The running sum is always visible on the output. In snapshot mode, a read strobe instead freezes the current sum into a holding register and restarts the accumulation from zero, both in a single cycle.

Top module: `fout_integrator`

Control word fields (bit position: meaning): 0 tap select (0 = pre-decimation stream, 1 = post-decimation stream); 1 run command; 2 hold command; 3 clear command; 4 gate for the run trigger; 5 gate for the hold trigger; 6 gate for the clear trigger; 7 snapshot read mode. Bits 1 to 3 are one-cycle commands. The other bits are stored on every write.

## Requirements
- R1: After reset the sum output is 0, the overflow flag is 0, run is 0, the tap selects the pre-decimation stream, all trigger gates are off and snapshot mode is off.
- R2: While running, every valid sample on the selected stream is sign-extended and added to the sum, and the new sum appears on the output one cycle after the sample.
- R3: Control bit 0 selects the stream (0 = pre-decimation, 1 = post-decimation). Samples and strobes on the stream that is not selected leave the sum unchanged.
- R4: Writing bit 1 sets run and writing bit 2 clears it, each from the next cycle on. A hold and a run in the same cycle leave run at 0. While run is 0, samples do not change the sum.
- R5: Writing bit 3 sets the sum and the overflow flag to zero. If a sample is accepted in the same cycle, the sum becomes that sample instead of zero.
- R6: A sum that would pass the signed accumulator limits is held at the largest or smallest value, and the overflow flag becomes 1. The flag stays at 1 until a clear.
- R7: A rising edge on the run, hold or clear trigger input acts like the matching command bit when its gate bit (4, 5 or 6) is set. A level that stays high acts only once. A trigger whose gate is off has no effect.
- R8: With bit 7 set, the sum output shows a snapshot register. A read strobe copies the current sum into that register and restarts the accumulator from zero, or from the sample accepted in that same cycle. With bit 7 clear, the output shows the live sum and the read strobe has no effect.
- R9: The run output reports whether the integrator is currently accumulating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_data_i | input | DATA_W | Pre-decimation result, signed |
| pre_valid_i | input | 1 | Pre-decimation result strobe |
| post_data_i | input | DATA_W | Post-decimation result, signed |
| post_valid_i | input | 1 | Post-decimation result strobe |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word |
| trg_run_i | input | 1 | Run trigger line |
| trg_hold_i | input | 1 | Hold trigger line |
| trg_clr_i | input | 1 | Clear trigger line |
| rd_stb_i | input | 1 | Read strobe |
| sum_o | output | ACC_W | Live sum, or the snapshot in snapshot mode |
| ovf_o | output | 1 | Sticky saturation flag |
| run_o | output | 1 | Integrator running |

## Verification
The bench builds the block with DATA_W=16, ACC_W=20 and SATURATE=1. With the accumulator only four bits wider than the samples, about seventeen full-scale samples reach either signed limit. This lets the bench check both saturation directions and the sticky flag in a short run. A 32-bit sum would need tens of thousands of samples to saturate. The saturating variant is the one that is built, so the limit-clamping property in the checker is active.

// File: rtl/fint_pkg.sv
package fint_pkg;
   localparam int CTL_W       = 8;
   localparam int F_TAP_POST  = 0;
   localparam int F_CMD_RUN   = 1;
   localparam int F_CMD_HOLD  = 2;
   localparam int F_CMD_CLR   = 3;
   localparam int F_GATE_RUN  = 4;
   localparam int F_GATE_HOLD = 5;
   localparam int F_GATE_CLR  = 6;
   localparam int F_RD_SNAP   = 7;

   localparam int NUM_TRIG = 3;
   localparam int TRG_RUN  = 0;
   localparam int TRG_HOLD = 1;
   localparam int TRG_CLR  = 2;

   typedef struct packed {
      logic rd_snap;
      logic gate_clr;
      logic gate_hold;
      logic gate_run;
      logic tap_post;
   } fint_cfg_t;
endpackage

// File: rtl/fint_edge.sv
module fint_edge #(
   parameter int NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] lvl_i,
   output logic [NUM-1:0] rise_o
);
   if (NUM < 1) begin : g_bad_num
      $error("fint_edge: NUM must be at least 1");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_det
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~prev_q;
   end
endmodule

// File: rtl/fint_ctl.sv
module fint_ctl
   import fint_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [CTL_W-1:0]    wdata_i,
   input  logic [NUM_TRIG-1:0] rise_i,
   output fint_cfg_t           cfg_o,
   output logic                run_o,
   output logic                run_cmd_o,
   output logic                hold_cmd_o,
   output logic                clr_cmd_o
);
   fint_cfg_t cfg_q;
   logic      run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we_i) begin
         cfg_q.tap_post  <= wdata_i[F_TAP_POST];
         cfg_q.gate_run  <= wdata_i[F_GATE_RUN];
         cfg_q.gate_hold <= wdata_i[F_GATE_HOLD];
         cfg_q.gate_clr  <= wdata_i[F_GATE_CLR];
         cfg_q.rd_snap   <= wdata_i[F_RD_SNAP];
      end
   end

   assign run_cmd_o  = (we_i & wdata_i[F_CMD_RUN])  | (cfg_q.gate_run  & rise_i[TRG_RUN]);
   assign hold_cmd_o = (we_i & wdata_i[F_CMD_HOLD]) | (cfg_q.gate_hold & rise_i[TRG_HOLD]);
   assign clr_cmd_o  = (we_i & wdata_i[F_CMD_CLR])  | (cfg_q.gate_clr  & rise_i[TRG_CLR]);

   always_ff @(posedge clk) begin
      if (!rst_n)          run_q <= 1'b0;
      else if (hold_cmd_o) run_q <= 1'b0;
      else if (run_cmd_o)  run_q <= 1'b1;
   end

   assign cfg_o = cfg_q;
   assign run_o = run_q;
endmodule

// File: rtl/fint_tap.sv
module fint_tap #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 32
) (
   input  logic              sel_post_i,
   input  logic [DATA_W-1:0] pre_data_i,
   input  logic              pre_valid_i,
   input  logic [DATA_W-1:0] post_data_i,
   input  logic              post_valid_i,
   output logic [ACC_W-1:0]  smp_o,
   output logic              vld_o
);
   localparam int EXT_W = ACC_W - DATA_W;

   logic [DATA_W-1:0] raw;

   always_comb begin
      if (sel_post_i) begin
         raw   = post_data_i;
         vld_o = post_valid_i;
      end else begin
         raw   = pre_data_i;
         vld_o = pre_valid_i;
      end
   end

   assign smp_o = {{EXT_W{raw[DATA_W-1]}}, raw};
endmodule

// File: rtl/fint_accum.sv
module fint_accum #(
   parameter int ACC_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_i,
   input  logic [ACC_W-1:0] smp_i,
   input  logic             zero_i,
   input  logic             flag_clr_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             ovf_o
);
   logic [ACC_W-1:0] acc_q;
   logic             ovf_q;
   logic [ACC_W-1:0] base;
   logic [ACC_W:0]   wide;
   logic             ovr;
   logic [ACC_W-1:0] res;

   always_comb begin
      base = zero_i ? '0 : acc_q;
      wide = {base[ACC_W-1], base} + {smp_i[ACC_W-1], smp_i};
      ovr  = wide[ACC_W] ^ wide[ACC_W-1];
   end

   if (SATURATE) begin : g_sat
      localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
      localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
      always_comb begin
         if (ovr) res = wide[ACC_W] ? ACC_MIN : ACC_MAX;
         else     res = wide[ACC_W-1:0];
      end
   end else begin : g_wrap
      assign res = wide[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         acc_q <= add_i ? res : base;
         ovf_q <= flag_clr_i ? 1'b0 : (ovf_q | (add_i & ovr));
      end
   end

   assign acc_o = acc_q;
   assign ovf_o = ovf_q;
endmodule

// File: rtl/fout_integrator.sv
module fout_integrator
   import fint_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ACC_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pre_data_i,
   input  logic              pre_valid_i,
   input  logic [DATA_W-1:0] post_data_i,
   input  logic              post_valid_i,
   input  logic              ctl_we_i,
   input  logic [CTL_W-1:0]  ctl_wdata_i,
   input  logic              trg_run_i,
   input  logic              trg_hold_i,
   input  logic              trg_clr_i,
   input  logic              rd_stb_i,
   output logic [ACC_W-1:0]  sum_o,
   output logic              ovf_o,
   output logic              run_o
);
   if (DATA_W < 2) begin : g_bad_data
      $error("fout_integrator: DATA_W must be at least 2");
   end
   if (ACC_W <= DATA_W) begin : g_bad_acc
      $error("fout_integrator: ACC_W must exceed DATA_W");
   end

   logic [NUM_TRIG-1:0] trg_lvl;
   logic [NUM_TRIG-1:0] trg_rise;
   fint_cfg_t           cfg;
   logic                run_cmd, hold_cmd, clr_cmd;
   logic [ACC_W-1:0]    smp;
   logic                smp_vld;
   logic                acc_ev;
   logic                rd_clr;
   logic                snap_mode;
   logic [ACC_W-1:0]    acc_q;
   logic [ACC_W-1:0]    snap_q;

   always_comb begin
      trg_lvl           = '0;
      trg_lvl[TRG_RUN]  = trg_run_i;
      trg_lvl[TRG_HOLD] = trg_hold_i;
      trg_lvl[TRG_CLR]  = trg_clr_i;
   end

   fint_edge #(.NUM(NUM_TRIG)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (trg_lvl),
      .rise_o (trg_rise)
   );

   fint_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (ctl_we_i),
      .wdata_i    (ctl_wdata_i),
      .rise_i     (trg_rise),
      .cfg_o      (cfg),
      .run_o      (run_o),
      .run_cmd_o  (run_cmd),
      .hold_cmd_o (hold_cmd),
      .clr_cmd_o  (clr_cmd)
   );

   fint_tap #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_tap (
      .sel_post_i   (cfg.tap_post),
      .pre_data_i   (pre_data_i),
      .pre_valid_i  (pre_valid_i),
      .post_data_i  (post_data_i),
      .post_valid_i (post_valid_i),
      .smp_o        (smp),
      .vld_o        (smp_vld)
   );

   assign acc_ev    = run_o & smp_vld;
   assign snap_mode = cfg.rd_snap;
   assign rd_clr    = rd_stb_i & snap_mode;

   fint_accum #(.ACC_W(ACC_W), .SATURATE(SATURATE)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .add_i      (acc_ev),
      .smp_i      (smp),
      .zero_i     (clr_cmd | rd_clr),
      .flag_clr_i (clr_cmd),
      .acc_o      (acc_q),
      .ovf_o      (ovf_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      snap_q <= '0;
      else if (rd_clr) snap_q <= acc_q;
   end

   assign sum_o = snap_mode ? snap_q : acc_q;
endmodule

// File: rtl/fout_integrator_chk.sv
module fout_integrator_chk #(
   parameter int ACC_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_o,
   input logic             ovf_o,
   input logic [ACC_W-1:0] sum_o,
   input logic [ACC_W-1:0] acc_q,
   input logic [ACC_W-1:0] smp,
   input logic             run_cmd,
   input logic             hold_cmd,
   input logic             clr_cmd,
   input logic             acc_ev,
   input logic             rd_clr,
   input logic             ctl_we_i
);
   localparam logic [ACC_W-1:0] LIM_HI = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] LIM_LO = {1'b1, {(ACC_W-1){1'b0}}};

   AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n) hold_cmd |=> !run_o); // R4
   AST_RUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (run_cmd && !hold_cmd) |=> run_o); // R4
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!run_o && !clr_cmd && !rd_clr) |=> $stable(acc_q)); // R4
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (clr_cmd && !acc_ev) |=> acc_q == '0); // R5
   AST_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (clr_cmd && acc_ev) |=> acc_q == $past(smp)); // R5
   AST_OVF_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr_cmd |=> !ovf_o); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_o && !clr_cmd) |=> ovf_o); // R6
   AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (rd_clr && !ctl_we_i) |=> sum_o == $past(acc_q)); // R8

   if (SATURATE) begin : g_sat_chk
      AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_o) |-> (acc_q == LIM_HI || acc_q == LIM_LO)); // R6
   end
endmodule

bind fout_integrator fout_integrator_chk #(.ACC_W(ACC_W), .SATURATE(SATURATE)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_o    (run_o),
   .ovf_o    (ovf_o),
   .sum_o    (sum_o),
   .acc_q    (acc_q),
   .smp      (smp),
   .run_cmd  (run_cmd),
   .hold_cmd (hold_cmd),
   .clr_cmd  (clr_cmd),
   .acc_ev   (acc_ev),
   .rd_clr   (rd_clr),
   .ctl_we_i (ctl_we_i)
);

// File: tb/fout_integrator_tb_top.sv
`timescale 1ns/1ps
module fout_integrator_tb_top;
   localparam int DATA_W = 16;
   localparam int ACC_W  = 20;
   localparam longint LIM_HI = (longint'(1) << (ACC_W-1)) - 1;
   localparam longint LIM_LO = -(longint'(1) << (ACC_W-1));

   typedef struct packed {
      logic        tap;
      logic        pv;
      logic [15:0] pd;
      logic        qv;
      logic [15:0] qd;
      int          exp;
   } vec_t;

   // sum starts at 0 with run enabled; exp is the sum after each row
   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b1, 16'd100,  1'b1, 16'd7,    100},
      '{1'b0, 1'b1, 16'hFFE2, 1'b0, 16'd0,    70},
      '{1'b0, 1'b0, 16'd500,  1'b1, 16'd9,    70},
      '{1'b1, 1'b1, 16'd1000, 1'b1, 16'hFFFB, 65},
      '{1'b1, 1'b0, 16'd0,    1'b1, 16'h8000, -32703},
      '{1'b1, 1'b0, 16'd0,    1'b1, 16'h7FFF, 64},
      '{1'b0, 1'b1, 16'hFFFF, 1'b0, 16'd0,    63},
      '{1'b0, 1'b1, 16'd0,    1'b0, 16'd0,    63}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] pre_data = '0, post_data = '0;
   logic              pre_valid = 1'b0, post_valid = 1'b0;
   logic              ctl_we = 1'b0;
   logic [7:0]        ctl_wdata = '0;
   logic              trg_run = 1'b0, trg_hold = 1'b0, trg_clr = 1'b0;
   logic              rd_stb = 1'b0;
   logic [ACC_W-1:0]  sum;
   logic              ovf, run;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit c_tap = 0, c_gr = 0, c_gh = 0, c_gc = 0, c_snap = 0;

   always #2.5 clk = ~clk;

   fout_integrator #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SATURATE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .pre_data_i(pre_data), .pre_valid_i(pre_valid),
      .post_data_i(post_data), .post_valid_i(post_valid),
      .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
      .trg_run_i(trg_run), .trg_hold_i(trg_hold), .trg_clr_i(trg_clr),
      .rd_stb_i(rd_stb), .sum_o(sum), .ovf_o(ovf), .run_o(run)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ssum();
      longint v = $signed(sum);
      return v;
   endfunction

   task automatic wr(bit en, bit hold, bit clr);
      ctl_we    = 1'b1;
      ctl_wdata = {c_snap, c_gc, c_gh, c_gr, clr, hold, en, c_tap};
      tick();
      ctl_we    = 1'b0;
   endtask

   task automatic smp(bit pv, logic [15:0] pd, bit qv, logic [15:0] qd);
      pre_valid = pv; pre_data = pd; post_valid = qv; post_data = qd;
      tick();
      pre_valid = 1'b0; post_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the run completed");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 sum after reset", ssum(), 0);
      chk("R1 ovf after reset", ovf, 0);
      chk("R1 run after reset", run, 0);

      // R4: held integrator ignores samples
      smp(1, 16'd50, 0, 16'd0);
      chk("R4 sample while held", ssum(), 0);
      wr(1, 0, 0);
      chk("R9 run after run command", run, 1);

      // table: R2 accumulation, R3 tap selection (default tap is pre)
      for (int i = 0; i < 8; i++) begin
         if (VEC[i].tap != c_tap) begin
            c_tap = VEC[i].tap;
            wr(0, 0, 0);
         end
         smp(VEC[i].pv, VEC[i].pd, VEC[i].qv, VEC[i].qd);
         chk($sformatf("R2 R3 row %0d", i), ssum(), longint'(VEC[i].exp));
      end

      // R4: hold and run together -> held
      wr(1, 1, 0);
      chk("R4 hold wins over run", run, 0);
      smp(1, 16'd10, 0, 16'd0);
      chk("R4 sum frozen while held", ssum(), 63);
      wr(1, 0, 0);

      // R5: clear, and clear together with a sample
      wr(0, 0, 1);
      chk("R5 clear to zero", ssum(), 0);
      smp(1, 16'd40, 0, 16'd0);
      chk("R2 add after clear", ssum(), 40);
      pre_valid = 1'b1; pre_data = 16'hFFF9;
      wr(0, 0, 1);
      pre_valid = 1'b0;
      chk("R5 clear with sample loads sample", ssum(), -7);

      // R6: positive saturation
      wr(0, 0, 1);
      for (int i = 0; i < 16; i++) smp(1, 16'h7FFF, 0, 16'd0);
      chk("R6 just below limit", ssum(), 16 * 32767);
      chk("R6 no ovf below limit", ovf, 0);
      smp(1, 16'h7FFF, 0, 16'd0);
      chk("R6 clamp high", ssum(), LIM_HI);
      chk("R6 ovf set high", ovf, 1);
      smp(1, 16'hFFFB, 0, 16'd0);
      chk("R6 sum after leaving limit", ssum(), LIM_HI - 5);
      chk("R6 ovf sticky", ovf, 1);
      wr(0, 0, 1);
      chk("R5 clear drops ovf", ovf, 0);

      // R6: negative saturation
      for (int i = 0; i < 16; i++) smp(1, 16'h8000, 0, 16'd0);
      chk("R6 exactly at low limit", ssum(), LIM_LO);
      chk("R6 no ovf at exact limit", ovf, 0);
      smp(1, 16'h8000, 0, 16'd0);
      chk("R6 clamp low", ssum(), LIM_LO);
      chk("R6 ovf set low", ovf, 1);
      wr(0, 0, 1);

      // R7: triggers
      trg_hold = 1'b1; tick();
      chk("R7 ungated hold trigger ignored", run, 1);
      trg_hold = 1'b0; tick();
      c_gr = 1; c_gh = 1; c_gc = 1;
      wr(0, 0, 0);
      trg_hold = 1'b1; tick();
      chk("R7 hold trigger edge", run, 0);
      trg_run = 1'b1; tick();
      chk("R7 run trigger edge with hold level high", run, 1);
      smp(1, 16'd25, 0, 16'd0);
      chk("R7 accumulate after trigger run", ssum(), 25);
      trg_clr = 1'b1; tick();
      chk("R7 clear trigger edge", ssum(), 0);
      smp(1, 16'd9, 0, 16'd0);
      chk("R7 clear level acts once", ssum(), 9);
      trg_run = 1'b0; trg_hold = 1'b0; trg_clr = 1'b0;
      tick();

      // R8: read strobe and snapshot mode
      rd_stb = 1'b1; tick(); rd_stb = 1'b0;
      chk("R8 read ignored without snapshot mode", ssum(), 9);
      smp(1, 16'd1, 0, 16'd0);
      c_snap = 1;
      wr(0, 0, 0);
      chk("R8 snapshot before first read", ssum(), 0);
      rd_stb = 1'b1; tick(); rd_stb = 1'b0;
      chk("R8 read captures sum", ssum(), 10);
      smp(1, 16'd4, 0, 16'd0);
      chk("R8 snapshot frozen", ssum(), 10);
      rd_stb = 1'b1; pre_valid = 1'b1; pre_data = 16'd6;
      tick();
      rd_stb = 1'b0; pre_valid = 1'b0;
      chk("R8 read with sample captures restart value", ssum(), 4);
      rd_stb = 1'b1; tick(); rd_stb = 1'b0;
      chk("R8 accumulator restarted from sample", ssum(), 6);
      c_snap = 0;
      wr(0, 0, 0);
      chk("R8 live sum after read clear", ssum(), 0);

      finish_run();
   end
endmodule